// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a synchronous serial port that owns the serial clock. It derives the clock from an 8-bit divisor and drives it only while a receive enable is active. On each falling edge of that clock it samples the data pin. Words of 8 or 9 bits are assembled least significant bit first and moved into a two-entry holding FIFO.

Software controls the block through a small register-style port. One write strobe loads the single-word enable, the continuous enable, the 9-bit mode bit and the interrupt enable. A read strobe pops the head word. The head word's data, ninth bit and framing-error bit are always visible, and so are the ready, interrupt and overrun flags.

In single-word mode the enable clears itself once the word has been taken, and the serial clock stops. In continuous mode words follow back to back until software clears the enable. A word that completes while the FIFO is full sets a sticky overrun flag. That flag blocks all further transfers until the continuous enable is cleared.

Top module: `sync_rx_master`

## Requirements
- R1: After reset the FIFO is empty, `ready_o`, `irq_o` and `ovr_o` are 0, both receive enables read back 0, and `sck_o` and `sck_oe_o` are 0.
- R2: While `port_en_i` is 1 and either enable is set, `sck_oe_o` is 1 and `sck_o` toggles with a high time and a low time of 2*(`div_i`+1) system clocks each, starting low. Otherwise `sck_o` and `sck_oe_o` are 0 from the next cycle.
- R3: `dt_i` is sampled as the serial clock falls. The first sampled bit is data bit 0, and bits follow in rising order. In 9-bit mode the bit sampled after data bit 7 becomes the entry's ninth bit. In 8-bit mode the ninth bit is stored as 0.
- R4: With only the single-word enable set, exactly one word is received. The enable then reads back 0 and the serial clock stays idle low.
- R5: With the continuous enable set, words are received back to back. If both enables are set, reception continues past the first word as in continuous mode.
- R6: Completed words enter a two-entry FIFO and are read in arrival order, one per `data_rd_i` pulse. `ready_o` rises when a word enters the FIFO and falls when reads have emptied it.
- R7: The ninth bit and the framing-error bit are held per entry. `rx9_o` and `ferr_o` always show the head entry and advance with each pop. The framing-error bit is always 0.
- R8: A word that completes while the FIFO holds two entries sets `ovr_o` and is discarded. While `ovr_o` is 1 no word enters the FIFO, and the flag stays set while the continuous enable stays 1.
- R9: While the continuous enable is 0, `ovr_o` is 0 from the next cycle.
- R10: `irq_o` is 1 exactly when `ready_o` is 1 and the interrupt enable is set.
- R11: Dropping `port_en_i`, or clearing both enables, aborts a partly received word. The next reception starts again from data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| div_i | input | DIV_W | Clock divisor; half period is 2*(div_i+1) cycles |
| cfg_we_i | input | 1 | Write strobe for the four control bits below |
| cfg_once_i | input | 1 | Single-word receive enable value |
| cfg_cont_i | input | 1 | Continuous receive enable value |
| cfg_nine_i | input | 1 | 9-bit mode value |
| cfg_ie_i | input | 1 | Interrupt enable value |
| data_rd_i | input | 1 | Pop the head FIFO entry |
| dt_i | input | 1 | Serial data pin |
| once_o | output | 1 | Single-word enable readback |
| cont_o | output | 1 | Continuous enable readback |
| rdata_o | output | 8 | Head entry data |
| rx9_o | output | 1 | Head entry ninth bit |
| ferr_o | output | 1 | Head entry framing-error bit |
| ready_o | output | 1 | FIFO holds at least one word |
| irq_o | output | 1 | Receive interrupt |
| ovr_o | output | 1 | Sticky overrun flag |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | Serial clock drive enable |

## Verification
The bound checker watches several rules on every cycle:
- The serial clock goes idle once the port is disabled.
- The single-word enable clears itself after a word completes.
- The overrun flag is sticky, is cleared by the continuous enable, and blocks FIFO fills.
- The FIFO never holds more than two entries, and `ready_o` falls on the final pop.
- No interrupt is raised without a ready word.

Some behaviour can only be shown by the bench's scenarios. These are the exact divisor timing, bit order and ninth-bit placement across sweeps of data values, the arrival order out of the FIFO, the loss of the third and fourth words on overrun, and the clean restart after an aborted word.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              bit9;
    logic              ferr;
  } rx_entry_t;
endpackage

// File: rtl/rx_sclk_gen.sv
module rx_sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             sck_q;
  logic             tick;

  // half period = 2*(div+1) cycles -> counter limit 2*div+1
  assign lim    = {div_i, 1'b1};
  assign tick   = (cnt_q >= lim);
  assign fall_o = run_i && tick && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          fall_i,
  input  logic          dt_i,
  input  logic          nine_i,
  output logic          done_o,
  output logic [DATA_W:0] word_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);

  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] last_bit;
  logic [DATA_W:0]  word_q;
  logic [DATA_W:0]  word_d;

  assign last_bit = nine_i ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  assign done_o   = fall_i && (bit_q == last_bit);
  assign word_o   = word_d;

  always_comb begin
    word_d        = word_q;
    word_d[bit_q] = dt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (!run_i) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (fall_i) begin
      if (done_o) begin
        bit_q  <= '0;
        word_q <= '0;
      end else begin
        bit_q  <= bit_q + 1'b1;
        word_q <= word_d;
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  rx_entry_t                  push_entry_i,
  input  logic                       pop_i,
  output rx_entry_t                  head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign head_o  = (cnt_q != '0) ? mem_q[rd_q] : '0;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_entry_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cfg_we_i,
  input  logic              cfg_once_i,
  input  logic              cfg_cont_i,
  input  logic              cfg_nine_i,
  input  logic              cfg_ie_i,
  input  logic              data_rd_i,
  input  logic              dt_i,
  output logic              once_o,
  output logic              cont_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rx9_o,
  output logic              ferr_o,
  output logic              ready_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              sck_o,
  output logic              sck_oe_o
);
  localparam int unsigned FIFO_CNT_W = $clog2(FIFO_DEPTH + 1);

  logic once_q, cont_q, nine_q, ie_q, ovr_q;
  logic run, fall, rx_done, rx_push, fifo_full;
  logic [DATA_W:0]       word;
  logic [FIFO_CNT_W-1:0] fifo_cnt;
  rx_entry_t             push_entry, head;

  assign run       = port_en_i && (once_q || cont_q);
  assign fifo_full = (fifo_cnt == FIFO_CNT_W'(FIFO_DEPTH));
  assign rx_push   = rx_done && !fifo_full && !ovr_q;

  always_comb begin
    push_entry.data = word[DATA_W-1:0];
    push_entry.bit9 = nine_q ? word[DATA_W] : 1'b0;
    push_entry.ferr = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      once_q <= 1'b0;
      cont_q <= 1'b0;
      nine_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (cfg_we_i) begin
      once_q <= cfg_once_i;
      cont_q <= cfg_cont_i;
      nine_q <= cfg_nine_i;
      ie_q   <= cfg_ie_i;
    end else if (rx_done) begin
      once_q <= 1'b0;
    end
  end

  // overrun is sticky; only a cleared continuous enable releases it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovr_q <= 1'b0;
    else if (!cont_q)             ovr_q <= 1'b0;
    else if (rx_done && fifo_full) ovr_q <= 1'b1;
  end

  rx_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .sck_o  (sck_o),
    .fall_o (fall)
  );

  rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .fall_i (fall),
    .dt_i   (dt_i),
    .nine_i (nine_q),
    .done_o (rx_done),
    .word_o (word)
  );

  rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (rx_push),
    .push_entry_i (push_entry),
    .pop_i        (data_rd_i),
    .head_o       (head),
    .count_o      (fifo_cnt)
  );

  assign once_o   = once_q;
  assign cont_o   = cont_q;
  assign rdata_o  = head.data;
  assign rx9_o    = head.bit9;
  assign ferr_o   = head.ferr;
  assign ready_o  = (fifo_cnt != '0);
  assign irq_o    = ready_o && ie_q;
  assign ovr_o    = ovr_q;
  assign sck_oe_o = run;
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk #(
  parameter int unsigned CNT_W = 2,
  parameter int unsigned DEPTH = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             port_en_i,
  input logic             cfg_we_i,
  input logic             data_rd_i,
  input logic             once_o,
  input logic             cont_o,
  input logic             ovr_o,
  input logic             ready_o,
  input logic             irq_o,
  input logic             sck_o,
  input logic             rx_done,
  input logic             rx_push,
  input logic [CNT_W-1:0] fifo_cnt
);
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> !sck_o); // R2
  AST_ONCE_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && !cfg_we_i) |=> !once_o); // R4
  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH)); // R6
  AST_LAST_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && fifo_cnt == CNT_W'(1) && !rx_push) |=> !ready_o); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && cont_o) |=> ovr_o); // R8
  AST_OVR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !data_rd_i) |=> (fifo_cnt == $past(fifo_cnt))); // R8
  AST_OVR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_o |=> !ovr_o); // R9
  AST_IRQ_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ready_o); // R10
endmodule

bind sync_rx_master sync_rx_master_chk #(
  .CNT_W (FIFO_CNT_W),
  .DEPTH (FIFO_DEPTH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .port_en_i (port_en_i),
  .cfg_we_i  (cfg_we_i),
  .data_rd_i (data_rd_i),
  .once_o    (once_o),
  .cont_o    (cont_o),
  .ovr_o     (ovr_o),
  .ready_o   (ready_o),
  .irq_o     (irq_o),
  .sck_o     (sck_o),
  .rx_done   (rx_done),
  .rx_push   (rx_push),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/sync_rx_master_bench.sv
module sync_rx_master_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b1;
  logic [7:0] div = 8'd1;
  logic       cfg_we = 1'b0, cfg_once = 1'b0, cfg_cont = 1'b0, cfg_nine = 1'b0, cfg_ie = 1'b0;
  logic       data_rd = 1'b0;
  logic       dt = 1'b0;
  logic       once_o, cont_o, rx9_o, ferr_o, ready_o, irq_o, ovr_o, sck_o, sck_oe_o;
  logic [7:0] rdata_o;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_rx_master u_sync_rx_master (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .div_i(div),
    .cfg_we_i(cfg_we), .cfg_once_i(cfg_once), .cfg_cont_i(cfg_cont),
    .cfg_nine_i(cfg_nine), .cfg_ie_i(cfg_ie), .data_rd_i(data_rd), .dt_i(dt),
    .once_o(once_o), .cont_o(cont_o), .rdata_o(rdata_o), .rx9_o(rx9_o),
    .ferr_o(ferr_o), .ready_o(ready_o), .irq_o(irq_o), .ovr_o(ovr_o),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic once, input logic cont, input logic nine, input logic ie);
    @(negedge clk);
    cfg_we = 1'b1; cfg_once = once; cfg_cont = cont; cfg_nine = nine; cfg_ie = ie;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive each bit after a rising serial edge; the design samples it on the following fall
  task automatic send_word(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge sck_o);
      #1;
      dt = v[i];
    end
    @(negedge sck_o);
    @(negedge clk);
  endtask

  task automatic pop_check(input logic [7:0] d, input logic b9, input string req);
    @(negedge clk);
    chk(ready_o, 1, req, "ready before pop");
    chk(rdata_o, d, req, "head data");
    chk(rx9_o, b9, req, "head ninth bit");
    chk(ferr_o, 0, "R7", "framing bit");
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic sweep(input logic nine);
    for (int k = 0; k < 16; k++) begin
      logic [8:0] a, b;
      a = 9'((k * 73 + 5) % 512);
      b = 9'((k * 151 + 300) % 512);
      cfg(1'b0, 1'b1, nine, 1'b0);
      send_word(a, nine ? 9 : 8);
      send_word(b, nine ? 9 : 8);
      cfg(1'b0, 1'b0, nine, 1'b0);
      chk(irq_o, 0, "R10", "irq masked while ready");
      pop_check(a[7:0], nine ? a[8] : 1'b0, "R3");
      pop_check(b[7:0], nine ? b[8] : 1'b0, "R6");
      chk(ready_o, 0, "R6", "ready after emptying");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held and just after release
    chk(ready_o, 0, "R1", "ready"); chk(irq_o, 0, "R1", "irq");
    chk(ovr_o, 0, "R1", "overrun"); chk(sck_o, 0, "R1", "sck");
    chk(sck_oe_o, 0, "R1", "sck drive"); chk(once_o, 0, "R1", "once");
    chk(cont_o, 0, "R1", "cont");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck_o, 0, "R1", "sck after release");

    // R2 divisor sweep: high and low half periods
    for (int d = 0; d < 8; d++) begin
      time t0, t1, t2;
      div = 8'(d);
      cfg(1'b0, 1'b1, 1'b0, 1'b0);
      chk(sck_oe_o, 1, "R2", "drive while active");
      @(posedge sck_o); t0 = $time;
      @(negedge sck_o); t1 = $time;
      @(posedge sck_o); t2 = $time;
      chk(int'((t1 - t0) / CLK_PERIOD), 2 * (d + 1), "R2", "high time");
      chk(int'((t2 - t1) / CLK_PERIOD), 2 * (d + 1), "R2", "low time");
      cfg(1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk(sck_o, 0, "R2", "idle after disable");
      chk(sck_oe_o, 0, "R2", "no drive after disable");
    end
    div = 8'd1;

    // R4 single-word mode with interrupt enabled
    cfg(1'b1, 1'b0, 1'b0, 1'b1);
    send_word(9'h0A5, 8);
    chk(once_o, 0, "R4", "once self-clears");
    chk(irq_o, 1, "R10", "irq when ready and enabled");
    repeat (40) @(negedge clk);
    chk(sck_o, 0, "R4", "clock idle after word");
    chk(sck_oe_o, 0, "R4", "clock not driven after word");
    pop_check(8'hA5, 1'b0, "R4");
    chk(ready_o, 0, "R4", "only one word");
    chk(irq_o, 0, "R10", "irq drops with ready");

    // R5 both enables: continuous wins
    cfg(1'b1, 1'b1, 1'b0, 1'b0);
    send_word(9'h03C, 8);
    send_word(9'h0C3, 8);
    chk(cont_o, 1, "R5", "continuous still set");
    chk(sck_oe_o, 1, "R5", "clock still running");
    cfg(1'b0, 1'b0, 1'b0, 1'b0);
    pop_check(8'h3C, 1'b0, "R5");
    pop_check(8'hC3, 1'b0, "R5");

    // R8/R9 overrun
    cfg(1'b0, 1'b1, 1'b0, 1'b0);
    send_word(9'h011, 8);
    send_word(9'h022, 8);
    chk(ovr_o, 0, "R8", "no overrun at two");
    send_word(9'h033, 8);
    chk(ovr_o, 1, "R8", "overrun on third");
    send_word(9'h044, 8);
    chk(ovr_o, 1, "R8", "overrun sticky");
    cfg(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(ovr_o, 0, "R9", "cleared with continuous enable");
    pop_check(8'h11, 1'b0, "R8");
    pop_check(8'h22, 1'b0, "R8");
    chk(ready_o, 0, "R8", "third and fourth discarded");
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    send_word(9'h055, 8);
    pop_check(8'h55, 1'b0, "R9");

    // R11 abort mid-word by port disable, then restart from bit 0
    cfg(1'b0, 1'b1, 1'b0, 1'b0);
    send_word(9'h0FF, 4);
    port_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(sck_oe_o, 0, "R11", "drive off while port disabled");
    port_en = 1'b1;
    send_word(9'h012, 8);
    cfg(1'b0, 1'b0, 1'b0, 1'b0);
    pop_check(8'h12, 1'b0, "R11");
    chk(ready_o, 0, "R11", "partial word not stored");

    // R3/R7 data sweeps in 9-bit and 8-bit modes
    sweep(1'b1);
    sweep(1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule